// File: doc/BRIEF.md
# PCM Sample Buffer with I2S Serial Output

This block takes 16-bit signed stereo PCM written by a processor one byte at a time and plays it out as a standard I2S stream. Four consecutive bytes form one stereo frame. The frame goes into an on-chip first-in first-out store that holds 1024 frames (4 KB) by default. A free-running serializer pulls one frame per audio frame period and shifts it out on a bit clock, a left/right word clock and a data line. The frame rate is the system clock divided by 64 times the half-bit divider, so the divider is chosen to give 48 kHz.

The buffer raises a low-water status whenever it holds less than a quarter of its capacity. Software uses that status, gated by an enable bit, as an interrupt request so that it refills the buffer before it runs dry. If the buffer is empty when a new frame starts, silence is played and nothing is consumed. Frames written while the buffer is full are discarded, and a sticky flag records the loss.

Top module: `pcm_i2s_out`

## Requirements
- R1: While and just after the synchronous reset, `bck`, `lrck` and `sdata` are low, `low_water` is high, `full_seen` is low and `irq` is low.
- R2: Bytes arrive in the order left low byte, left high byte, right low byte, right high byte. A frame enters the buffer only when its fourth byte is written, so three bytes alone never reach the output.
- R3: Committed frames are played out in write order, each exactly once.
- R4: Each frame is 32 bit clocks long. `lrck` is low for the left sample and high for the right sample. Each sample is sent MSB first, starting one bit clock after the `lrck` edge. `lrck` and `sdata` change only on falling edges of `bck`.
- R5: One `bck` period is 2*BCK_HALF system clocks, and one frame (`lrck` fall to `lrck` fall) is 64*BCK_HALF system clocks.
- R6: When the buffer is empty at a frame start, a frame of zeros is sent and no stored frame is skipped, so the next frame written is the next one played.
- R7: A frame completed while the buffer is full is dropped, the stored contents are unchanged, and `full_seen` goes high and stays high until reset.
- R8: `low_water` is high exactly when the buffer holds fewer than DEPTH/4 frames. For a depth of 64 frames it is high at 15 frames and low at 16.
- R9: `irq` equals `low_water` AND `irq_en`, one clock later.
- R10: Reset discards a partly written frame and empties the buffer, so the next four bytes after reset form a whole new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte of PCM data |
| irq_en | input | 1 | Enables the low-water interrupt |
| bck | output | 1 | I2S bit clock |
| lrck | output | 1 | I2S word clock, low for the left channel |
| sdata | output | 1 | I2S serial data, MSB first |
| low_water | output | 1 | Buffer holds less than a quarter of capacity |
| full_seen | output | 1 | Sticky: a frame was dropped because the buffer was full |
| irq | output | 1 | Low-water interrupt request |

## Verification
The hardest state to reach is a full buffer, because the serializer drains one frame every period and never pauses. The bench uses a 64-frame depth and a bit-clock divider of 8. It waits for a word-clock fall, then writes 66 frames back to back, one byte per cycle. The whole burst therefore lands before the next pop, so exactly two frames are dropped. The same alignment places the buffer at exactly 15 and then 16 frames to test the low-water threshold. An I2S receiver model in the bench decodes the stream on rising bit-clock edges.

// File: rtl/pcm_i2s_pkg.sv
package pcm_i2s_pkg;
  localparam int SAMPLE_W   = 16;
  localparam int FRAME_W    = 2 * SAMPLE_W;
  localparam int BYTE_W     = 8;
  localparam int FRAME_BYTES = FRAME_W / BYTE_W;

  // packed so that the little-endian byte stream lands directly
  typedef struct packed {
    logic [SAMPLE_W-1:0] right;
    logic [SAMPLE_W-1:0] left;
  } pcm_frame_t;
endpackage

// File: rtl/pcm_frame_packer.sv
module pcm_frame_packer
  import pcm_i2s_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output pcm_frame_t        frame,
  output logic              commit
);
  localparam int IW  = $clog2(FRAME_BYTES);
  localparam int ACC = FRAME_W - BYTE_W;

  logic [IW-1:0]  idx;
  logic [ACC-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx    <= '0;
      commit <= 1'b0;
    end else begin
      commit <= 1'b0;
      if (wr_en) begin
        if (idx == IW'(FRAME_BYTES - 1)) begin
          frame  <= pcm_frame_t'({wr_data, acc});
          commit <= 1'b1;
          idx    <= '0;
        end else begin
          acc <= {wr_data, acc[ACC-1:BYTE_W]};
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // R2: a frame is emitted only once the byte index has wrapped
  assert_commit_on_last_byte_R2: assert property (@(posedge clk) disable iff (rst)
    commit |-> (idx == '0 && $past(wr_en)));
endmodule

// File: rtl/pcm_frame_fifo.sv
module pcm_frame_fifo
  import pcm_i2s_pkg::*;
#(
  parameter int DEPTH_LOG2 = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       push,
  input  pcm_frame_t din,
  input  logic       pop,
  output pcm_frame_t dout,
  output logic       dout_valid,
  output logic       low_water,
  output logic       full_seen
);
  localparam int DEPTH   = 1 << DEPTH_LOG2;
  localparam int QUARTER = DEPTH / 4;
  localparam int AW      = DEPTH_LOG2;

  pcm_frame_t    mem [DEPTH];
  logic [AW:0]   wptr, rptr, count;
  logic          full, empty;

  assign count = wptr - rptr;
  assign full  = (count == (AW+1)'(DEPTH));
  assign empty = (count == '0);

  // storage port: written so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (push && !full) mem[wptr[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (pop && !empty) dout <= mem[rptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr       <= '0;
      rptr       <= '0;
      dout_valid <= 1'b0;
      low_water  <= 1'b1;
      full_seen  <= 1'b0;
    end else begin
      if (push && !full) wptr <= wptr + 1'b1;
      if (push && full)  full_seen <= 1'b1;
      if (pop) begin
        dout_valid <= !empty;
        if (!empty) rptr <= rptr + 1'b1;
      end
      low_water <= (count < (AW+1)'(QUARTER));
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> $stable(wptr));
  assert_occupancy_bound_R7: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(DEPTH));
  assert_empty_keeps_rptr_R6: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> ($stable(rptr) && !dout_valid));
  assert_full_not_low_R8: assert property (@(posedge clk) disable iff (rst)
    full |=> !low_water);
endmodule

// File: rtl/i2s_serializer.sv
module i2s_serializer
  import pcm_i2s_pkg::*;
#(
  parameter int BCK_HALF = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  pcm_frame_t frame,
  input  logic       frame_valid,
  output logic       pop,
  output logic       bck,
  output logic       lrck,
  output logic       sdata
);
  localparam int DW    = $clog2(BCK_HALF + 1);
  localparam int SLOTS = FRAME_W;
  localparam int SW    = $clog2(SLOTS);

  logic [DW-1:0]      div;
  logic [SW-1:0]      slot, next_slot;
  logic [FRAME_W-1:0] shreg;
  logic               tick, fall;

  assign tick      = (div == DW'(BCK_HALF - 1));
  assign fall      = tick && bck;
  assign next_slot = slot + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      div   <= '0;
      bck   <= 1'b0;
      slot  <= '0;
      lrck  <= 1'b0;
      sdata <= 1'b0;
      shreg <= '0;
      pop   <= 1'b0;
    end else begin
      pop <= 1'b0;
      if (tick) begin
        div <= '0;
        bck <= ~bck;
      end else begin
        div <= div + 1'b1;
      end
      if (fall) begin
        slot  <= next_slot;
        lrck  <= next_slot[SW-1];
        // the bit shifted out in slot 0 is the previous right LSB
        sdata <= shreg[FRAME_W-1];
        if (next_slot == '0)
          shreg <= frame_valid ? {frame.left, frame.right} : '0;
        else
          shreg <= shreg << 1;
        if (next_slot == SW'(SLOTS - 2)) pop <= 1'b1;
      end
    end
  end

  assert_lrck_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(lrck) |-> $fell(bck));
  assert_sdata_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata) |-> $fell(bck));
  assert_single_pop_R3: assert property (@(posedge clk) disable iff (rst)
    pop |=> !pop);
endmodule

// File: rtl/pcm_i2s_out.sv
module pcm_i2s_out
  import pcm_i2s_pkg::*;
#(
  parameter int DEPTH_LOG2 = 10,
  parameter int BCK_HALF   = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        irq_en,
  output logic        bck,
  output logic        lrck,
  output logic        sdata,
  output logic        low_water,
  output logic        full_seen,
  output logic        irq
);
  pcm_frame_t packed_frame, head_frame;
  logic       commit, pop, head_valid;

  pcm_frame_packer u_packer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .frame(packed_frame), .commit(commit)
  );

  pcm_frame_fifo #(.DEPTH_LOG2(DEPTH_LOG2)) u_fifo (
    .clk(clk), .rst(rst), .push(commit), .din(packed_frame),
    .pop(pop), .dout(head_frame), .dout_valid(head_valid),
    .low_water(low_water), .full_seen(full_seen)
  );

  i2s_serializer #(.BCK_HALF(BCK_HALF)) u_ser (
    .clk(clk), .rst(rst), .frame(head_frame), .frame_valid(head_valid),
    .pop(pop), .bck(bck), .lrck(lrck), .sdata(sdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= low_water & irq_en;
  end

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);
  assert_full_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    full_seen |=> full_seen);
endmodule

// File: tb/tb_pcm_i2s_out.sv
module tb_pcm_i2s_out;
  localparam int BH = 8;
  localparam int DL = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic irq_en = 1'b0;
  logic bck, lrck, sdata, low_water, full_seen, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pcm_i2s_out #(.DEPTH_LOG2(DL), .BCK_HALF(BH)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .irq_en(irq_en),
    .bck(bck), .lrck(lrck), .sdata(sdata), .low_water(low_water),
    .full_seen(full_seen), .irq(irq)
  );

  // I2S receiver model: samples data on rising bit clock
  logic [31:0] rx [256];
  int rx_cnt = 0;
  logic [31:0] sh = '0;
  logic prev_bck = 1'b0, prev_lr = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      prev_bck = 1'b0; prev_lr = 1'b0; sh = '0;
    end else begin
      if (bck && !prev_bck) begin
        sh = {sh[30:0], sdata};
        if (!lrck && prev_lr) begin
          rx[rx_cnt % 256] = sh;
          rx_cnt++;
        end
        prev_lr = lrck;
      end
      prev_bck = bck;
    end
  end

  function automatic logic [15:0] fl(int k);
    return 16'h8001 + 16'(k) * 16'h0101;
  endfunction
  function automatic logic [15:0] fr(int k);
    return 16'h7F3C - 16'(k) * 16'h0203;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic put_frame_fast(input int k);
    logic [15:0] l, r;
    l = fl(k); r = fr(k);
    @(negedge clk); wr_en = 1'b1; wr_data = l[7:0];
    @(negedge clk); wr_data = l[15:8];
    @(negedge clk); wr_data = r[7:0];
    @(negedge clk); wr_data = r[15:8];
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic burst(input int k0, input int n);
    for (int i = 0; i < n; i++) begin
      logic [15:0] l, r;
      l = fl(k0 + i); r = fr(k0 + i);
      @(negedge clk); wr_en = 1'b1; wr_data = l[7:0];
      @(negedge clk); wr_data = l[15:8];
      @(negedge clk); wr_data = r[7:0];
      @(negedge clk); wr_data = r[15:8];
    end
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_rx(input int target);
    while (rx_cnt < target) @(negedge clk);
  endtask

  // find the first non-silent frame, compare n frames, then expect silence
  task automatic check_stream(input int base, input int k0, input int n, input string tag);
    int j;
    wait_rx(base + n + 4);
    j = base;
    while (j < base + 4 && rx[j % 256] == 32'h0) j++;
    for (int i = 0; i < n; i++)
      chk(rx[(j + i) % 256] == {fl(k0 + i), fr(k0 + i)}, tag,
          rx[(j + i) % 256], {fl(k0 + i), fr(k0 + i)});
    chk(rx[(j + n) % 256] == 32'h0, {tag, " R6 silence after data"}, rx[(j + n) % 256], 32'h0);
  endtask

  task automatic wait_lrck_fall;
    @(negedge clk); while (!lrck) @(negedge clk);
    while (lrck) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(bck == 0 && lrck == 0 && sdata == 0, "R1 serial lines", {bck, lrck, sdata}, 0);
    chk(low_water == 1, "R1 low_water", low_water, 1);
    chk(full_seen == 0, "R1 full_seen", full_seen, 0);
    chk(irq == 0, "R1 irq", irq, 0);
  endtask

  task automatic t_irq;
    irq_en = 1'b1; repeat (3) @(negedge clk);
    chk(irq == 1, "R9 irq enabled", irq, 1);
    irq_en = 1'b0; repeat (3) @(negedge clk);
    chk(irq == 0, "R9 irq masked", irq, 0);
  endtask

  task automatic t_timing;
    int t0, t1, f0, f1, c;
    c = 0;
    @(negedge clk); while (bck) @(negedge clk);
    while (!bck) begin @(negedge clk); c++; end
    t0 = c;
    while (bck) begin @(negedge clk); c++; end
    while (!bck) begin @(negedge clk); c++; end
    t1 = c;
    chk(t1 - t0 == 2 * BH, "R5 bck period", t1 - t0, 2 * BH);
    wait_lrck_fall;
    f0 = 0;
    while (!lrck) begin @(negedge clk); f0++; end
    f1 = f0;
    while (lrck) begin @(negedge clk); f1++; end
    chk(f0 == 32 * BH, "R4 left half length", f0, 32 * BH);
    chk(f1 == 64 * BH, "R5 frame length", f1, 64 * BH);
  endtask

  task automatic t_basic;
    int base;
    base = rx_cnt;
    for (int k = 0; k < 4; k++) put_frame_fast(k);
    check_stream(base, 0, 4, "R2 R3 R4 basic stream");
  endtask

  task automatic t_partial;
    int base;
    logic [15:0] l, r;
    l = fl(10); r = fr(10);
    base = rx_cnt;
    put_byte(l[7:0]); put_byte(l[15:8]); put_byte(r[7:0]);
    wait_rx(base + 3);
    for (int i = 0; i < 3; i++)
      chk(rx[(base + i) % 256] == 32'h0, "R2 three bytes not played", rx[(base + i) % 256], 0);
    base = rx_cnt;
    put_byte(r[15:8]);
    check_stream(base, 10, 1, "R2 R6 completed frame");
  endtask

  task automatic t_reset_partial;
    int base;
    put_byte(8'hAA); put_byte(8'h55);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    chk(low_water == 1 && full_seen == 0, "R10 flags after reset", {low_water, full_seen}, 2'b10);
    base = rx_cnt;
    put_frame_fast(30);
    check_stream(base, 30, 1, "R10 fresh frame after reset");
  endtask

  task automatic t_threshold;
    int base;
    wait_lrck_fall;
    base = rx_cnt;
    burst(40, 15);
    repeat (4) @(negedge clk);
    chk(low_water == 1, "R8 fifteen frames", low_water, 1);
    burst(55, 1);
    repeat (4) @(negedge clk);
    chk(low_water == 0, "R8 sixteen frames", low_water, 0);
    check_stream(base, 40, 16, "R3 threshold drain");
    chk(low_water == 1, "R8 low after drain", low_water, 1);
  endtask

  task automatic t_full;
    int base;
    wait_lrck_fall;
    base = rx_cnt;
    chk(full_seen == 0, "R7 flag clear before burst", full_seen, 0);
    burst(100, 66);
    repeat (4) @(negedge clk);
    chk(full_seen == 1, "R7 flag set", full_seen, 1);
    chk(low_water == 0, "R8 full not low", low_water, 0);
    check_stream(base, 100, 64, "R7 dropped frames absent");
    chk(full_seen == 1, "R7 flag sticky", full_seen, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset;
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset;
    t_irq;
    t_timing;
    t_basic;
    t_partial;
    t_reset_partial;
    t_threshold;
    t_full;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule